// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block loads a device's operating parameters from a serial bit stream. Bits arrive on the upper-neighbor input and move through a 183-stage shift register, one stage per enabled system clock. The bit leaving the last stage goes to the lower-neighbor output, so any number of devices can sit in one chain and be loaded by a single long stream. Shifting happens only while a latched mode flag selects initialization. That flag changes only when a change-mode strobe is pulsed.

The first 128 stages hold the per-channel mask, and the block drives it straight from the shift register. The remaining 55 stages hold control bits: 15 for the front end and 40 for the back end. A rising edge on the latch strobe, seen while in initialization, copies these control bits into holding registers. The same edge also issues a one-cycle reset pulse for an external pipeline cell pointer. The block decodes the held bits into named fields.

Stream numbering used below: bit n is the n-th bit shifted in, counting from 1.

Top module: `cfg_chain_loader`

## Requirements
- R1: After asynchronous reset (rst_ni low), the following outputs are 0: all decoded fields, chan_mask_o, init_mode_o, ptr_rst_o and ser_o.
- R2: init_mode_o takes the value of mode_init_i only on a clock edge where mode_chg_i is 1. A change on mode_init_i at any other time has no effect.
- R3: The shift register advances by one bit, taking ser_i, only on clock edges where shift_en_i is 1 and init_mode_o is 1. At all other times its contents are kept.
- R4: ser_o is registered. While in initialization it shows the bit that was shifted in 183 enabled shifts earlier, so bits leave in the order they entered. Outside initialization ser_o is 0.
- R5: chan_mask_o[j] equals stream bit j+1 of the last 183 bits shifted. It follows the shift register directly, without any strobe.
- R6: Decoded control fields change only on the clock edge after a rising edge of strobe_i that is seen while in initialization. At that edge they take stream bits 129 to 183. Stream bits 151 to 154 are spares that reach no output.
- R7: A rising edge of strobe_i seen while in initialization produces ptr_rst_o high for exactly one cycle, on the same edge at which the fields update. Outside initialization no pulse is produced.
- R8: Front-end field mapping:
  - cal_dir_o = bit 129
  - pipe_sel_o = bit 130
  - bandwidth_o[j] = bit 131+j
  - pipe_delay_o[j] = bit 137+j
  - pipe_pol_o = bit 143
- R9: Back-end field mapping:
  - chip_id_o[j] = bit 144+j
  - last_chip_o = bit 155
  - read_nbr_o = bit 156
  - read_all_o = bit 157
  - ramp_dir_o = bit 158
  - comp_dir_o = bit 159
  - ramp_cap_o[7-j] = bit 160+j
  - threshold_o[j] = bit 168+j
  - cnt_mod_o[7-j] = bit 176+j
- R10: Holding strobe_i high for several cycles latches once and gives a single ptr_rst_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_chg_i | input | 1 | Change-mode strobe; samples mode_init_i |
| mode_init_i | input | 1 | Requested mode, 1 = initialization |
| shift_en_i | input | 1 | Serial data valid / shift enable |
| ser_i | input | 1 | Serial data from upper neighbor |
| strobe_i | input | 1 | Control latch strobe |
| ser_o | output | 1 | Serial data to lower neighbor |
| chan_mask_o | output | 128 | Channel mask, channel 0 at bit 0 |
| cal_dir_o | output | 1 | Calibration direction |
| pipe_sel_o | output | 1 | Pipeline select |
| bandwidth_o | output | 6 | Bandwidth setting |
| pipe_delay_o | output | 6 | Pipeline delay |
| pipe_pol_o | output | 1 | Pipeline polarity |
| chip_id_o | output | 7 | Chip identifier |
| last_chip_o | output | 1 | Last device in chain |
| read_nbr_o | output | 1 | Read neighbor channels |
| read_all_o | output | 1 | Read every channel |
| ramp_dir_o | output | 1 | Ramp direction |
| comp_dir_o | output | 1 | Comparator direction |
| ramp_cap_o | output | 8 | Ramp capacitance adjust |
| threshold_o | output | 8 | Sparsification threshold |
| cnt_mod_o | output | 8 | Counter modulo |
| ptr_rst_o | output | 1 | Pipeline pointer reset pulse |
| init_mode_o | output | 1 | Latched initialization mode |

## Verification
A shift register that drops or repeats a bit shows up on ser_o on the very next enabled shift. The bench compares every output bit against the previous stream, so the error is seen within one shift and cannot wait for a whole frame. A wrong position inside the chain does not surface on ser_o until that bit reaches the end. It does show at once on chan_mask_o, and on the decoded fields one cycle after the strobe. A mode flag that is not held correctly shows as a stray pulse on ptr_rst_o, or as fields that move when no strobe edge occurred.

// File: rtl/cfg_chain_pkg.sv
`timescale 1ns/1ps
package cfg_chain_pkg;
  localparam int MASK_W  = 128;
  localparam int FE_W    = 15;
  localparam int BE_W    = 40;
  localparam int CTL_W   = FE_W + BE_W;
  localparam int CHAIN_W = MASK_W + CTL_W;

  // offsets inside the control section (index 0 = stream bit MASK_W+1)
  localparam int CAL_OFS  = 0;
  localparam int PSEL_OFS = 1;
  localparam int BW_OFS   = 2;
  localparam int BW_W     = 6;
  localparam int DLY_OFS  = 8;
  localparam int DLY_W    = 6;
  localparam int POL_OFS  = 14;
  localparam int ID_OFS   = FE_W;
  localparam int ID_W     = 7;
  localparam int LAST_OFS = 26;
  localparam int RNB_OFS  = 27;
  localparam int RALL_OFS = 28;
  localparam int RUD_OFS  = 29;
  localparam int CUD_OFS  = 30;
  localparam int RCAP_OFS = 31;
  localparam int THR_OFS  = 39;
  localparam int CMOD_OFS = 47;
  localparam int BYTE_W   = 8;

  typedef struct packed {
    logic              cal_dir;
    logic              pipe_sel;
    logic [BW_W-1:0]   bandwidth;
    logic [DLY_W-1:0]  pipe_delay;
    logic              pipe_pol;
    logic [ID_W-1:0]   chip_id;
    logic              last_chip;
    logic              read_nbr;
    logic              read_all;
    logic              ramp_dir;
    logic              comp_dir;
    logic [BYTE_W-1:0] ramp_cap;
    logic [BYTE_W-1:0] threshold;
    logic [BYTE_W-1:0] cnt_mod;
  } cfg_fields_t;
endpackage

// File: rtl/cfg_mode_ctl.sv
`timescale 1ns/1ps
module cfg_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_chg_i,
  input  logic mode_init_i,
  input  logic strobe_i,
  output logic init_o,
  output logic latch_o,
  output logic ptr_rst_o
);
  logic strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o    <= 1'b0;
      strb_q    <= 1'b0;
      ptr_rst_o <= 1'b0;
    end else begin
      if (mode_chg_i) init_o <= mode_init_i;
      strb_q    <= strobe_i;
      ptr_rst_o <= latch_o;
    end
  end

  // rising strobe edge, honoured only in init mode
  assign latch_o = strobe_i & ~strb_q & init_o;

  p_mode_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> init_o == $past(mode_init_i));
  p_mode_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_chg_i |=> $stable(init_o));
  p_ptr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !strb_q && init_o) |=> ptr_rst_o);
  p_ptr_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_o |=> !ptr_rst_o);
endmodule

// File: rtl/cfg_shift_chain.sv
`timescale 1ns/1ps
module cfg_shift_chain #(
  parameter int W = 183
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] chain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   chain_o <= '0;
    else if (en_i) chain_o <= {chain_o[W-2:0], din_i};
  end

  p_shift_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> chain_o[0] == $past(din_i));
  p_shift_move_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> chain_o[W-1] == $past(chain_o[W-2]));
endmodule

// File: rtl/cfg_ctl_hold.sv
`timescale 1ns/1ps
module cfg_ctl_hold #(
  parameter int W = 55
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] src_i,
  output logic [0:W-1] ctl_o
);
  logic [0:W-1] remap;

  // ctl_o[i] holds the i-th control bit in stream order
  for (genvar i = 0; i < W; i++) begin : g_remap
    assign remap[i] = src_i[W-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_o <= '0;
    else if (load_i) ctl_o <= remap;
  end

  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ctl_o));
endmodule

// File: rtl/cfg_field_decode.sv
`timescale 1ns/1ps
module cfg_field_decode
  import cfg_chain_pkg::*;
(
  input  logic [0:CTL_W-1] ctl_i,
  output cfg_fields_t      fld_o
);
  always_comb begin
    fld_o           = '0;
    fld_o.cal_dir   = ctl_i[CAL_OFS];
    fld_o.pipe_sel  = ctl_i[PSEL_OFS];
    fld_o.pipe_pol  = ctl_i[POL_OFS];
    fld_o.last_chip = ctl_i[LAST_OFS];
    fld_o.read_nbr  = ctl_i[RNB_OFS];
    fld_o.read_all  = ctl_i[RALL_OFS];
    fld_o.ramp_dir  = ctl_i[RUD_OFS];
    fld_o.comp_dir  = ctl_i[CUD_OFS];
    for (int j = 0; j < BW_W; j++)  fld_o.bandwidth[j]  = ctl_i[BW_OFS+j];
    for (int j = 0; j < DLY_W; j++) fld_o.pipe_delay[j] = ctl_i[DLY_OFS+j];
    for (int j = 0; j < ID_W; j++)  fld_o.chip_id[j]    = ctl_i[ID_OFS+j];
    for (int j = 0; j < BYTE_W; j++) begin
      fld_o.threshold[j]          = ctl_i[THR_OFS+j];
      fld_o.ramp_cap[BYTE_W-1-j]  = ctl_i[RCAP_OFS+j];
      fld_o.cnt_mod[BYTE_W-1-j]   = ctl_i[CMOD_OFS+j];
    end
  end
endmodule

// File: rtl/cfg_chain_loader.sv
`timescale 1ns/1ps
module cfg_chain_loader
  import cfg_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_chg_i,
  input  logic              mode_init_i,
  input  logic              shift_en_i,
  input  logic              ser_i,
  input  logic              strobe_i,
  output logic              ser_o,
  output logic [MASK_W-1:0] chan_mask_o,
  output logic              cal_dir_o,
  output logic              pipe_sel_o,
  output logic [BW_W-1:0]   bandwidth_o,
  output logic [DLY_W-1:0]  pipe_delay_o,
  output logic              pipe_pol_o,
  output logic [ID_W-1:0]   chip_id_o,
  output logic              last_chip_o,
  output logic              read_nbr_o,
  output logic              read_all_o,
  output logic              ramp_dir_o,
  output logic              comp_dir_o,
  output logic [BYTE_W-1:0] ramp_cap_o,
  output logic [BYTE_W-1:0] threshold_o,
  output logic [BYTE_W-1:0] cnt_mod_o,
  output logic              ptr_rst_o,
  output logic              init_mode_o
);
  logic               init_q;
  logic               latch;
  logic [CHAIN_W-1:0] chain;
  logic [0:CTL_W-1]   ctl;
  cfg_fields_t        fld;

  cfg_mode_ctl u_mode (
    .clk_i, .rst_ni, .mode_chg_i, .mode_init_i, .strobe_i,
    .init_o(init_q), .latch_o(latch), .ptr_rst_o
  );

  cfg_shift_chain #(.W(CHAIN_W)) u_chain (
    .clk_i, .rst_ni, .en_i(shift_en_i & init_q), .din_i(ser_i), .chain_o(chain)
  );

  cfg_ctl_hold #(.W(CTL_W)) u_hold (
    .clk_i, .rst_ni, .load_i(latch), .src_i(chain[CTL_W-1:0]), .ctl_o(ctl)
  );

  cfg_field_decode u_dec (.ctl_i(ctl), .fld_o(fld));

  // first bit shifted sits at the far end of the chain
  for (genvar j = 0; j < MASK_W; j++) begin : g_mask
    assign chan_mask_o[j] = chain[CHAIN_W-1-j];
  end

  assign ser_o        = init_q & chain[CHAIN_W-1];
  assign init_mode_o  = init_q;
  assign cal_dir_o    = fld.cal_dir;
  assign pipe_sel_o   = fld.pipe_sel;
  assign bandwidth_o  = fld.bandwidth;
  assign pipe_delay_o = fld.pipe_delay;
  assign pipe_pol_o   = fld.pipe_pol;
  assign chip_id_o    = fld.chip_id;
  assign last_chip_o  = fld.last_chip;
  assign read_nbr_o   = fld.read_nbr;
  assign read_all_o   = fld.read_all;
  assign ramp_dir_o   = fld.ramp_dir;
  assign comp_dir_o   = fld.comp_dir;
  assign ramp_cap_o   = fld.ramp_cap;
  assign threshold_o  = fld.threshold;
  assign cnt_mod_o    = fld.cnt_mod;

  p_idle_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> $stable(chain));
  p_no_ptr_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> !ptr_rst_o);
  p_fields_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_rst_o |-> $stable(ctl));
endmodule

// File: tb/cfg_chain_loader_test.sv
`timescale 1ns/1ps
module cfg_chain_loader_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_chg = 0, mode_init = 0, shift_en = 0, ser_in = 0, strobe = 0;
  logic ser_out, cal_dir, pipe_sel, pipe_pol, last_chip, read_nbr, read_all;
  logic ramp_dir, comp_dir, ptr_rst, init_mode;
  logic [127:0] mask;
  logic [5:0] bw, dly;
  logic [6:0] cid;
  logic [7:0] rcap, thr, cmod;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_chain_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_chg_i(mode_chg), .mode_init_i(mode_init),
    .shift_en_i(shift_en), .ser_i(ser_in), .strobe_i(strobe), .ser_o(ser_out),
    .chan_mask_o(mask), .cal_dir_o(cal_dir), .pipe_sel_o(pipe_sel),
    .bandwidth_o(bw), .pipe_delay_o(dly), .pipe_pol_o(pipe_pol), .chip_id_o(cid),
    .last_chip_o(last_chip), .read_nbr_o(read_nbr), .read_all_o(read_all),
    .ramp_dir_o(ramp_dir), .comp_dir_o(comp_dir), .ramp_cap_o(rcap),
    .threshold_o(thr), .cnt_mod_o(cmod), .ptr_rst_o(ptr_rst), .init_mode_o(init_mode)
  );

  // {fields[50:0], mask seed[31:0]}; fields: cal,psel,bw6,dly6,pol,id7,last,rnb,rall,rud,cud,rcap8,thr8,cmod8
  localparam logic [82:0] VEC [0:2] = '{
    {51'h5_A3C6_1E2D_4B87, 32'hC3A5_0F91},
    {51'h2_5C39_E1D2_B478, 32'h1234_5678},
    {51'h7_FFFF_0000_FFFF, 32'h8000_0001}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mask_of(input logic [31:0] s);
    return {s, ~s, s ^ 32'hFFFF_0000, s};
  endfunction

  function automatic logic [1:183] build(input logic [82:0] v);
    logic [1:183] s;
    logic [50:0] f = v[82:32];
    logic [127:0] m = mask_of(v[31:0]);
    for (int j = 0; j < 128; j++) s[1+j] = m[j];
    s[129] = f[50];
    s[130] = f[49];
    for (int j = 0; j < 6; j++) s[131+j] = f[43+j];
    for (int j = 0; j < 6; j++) s[137+j] = f[37+j];
    s[143] = f[36];
    for (int j = 0; j < 7; j++) s[144+j] = f[29+j];
    s[151:154] = 4'b1011;
    s[155] = f[28]; s[156] = f[27]; s[157] = f[26]; s[158] = f[25]; s[159] = f[24];
    for (int j = 0; j < 8; j++) begin
      s[160+j] = f[16+7-j];
      s[168+j] = f[8+j];
      s[176+j] = f[7-j];
    end
    return s;
  endfunction

  function automatic logic [50:0] fields_now();
    return {cal_dir, pipe_sel, bw, dly, pipe_pol, cid, last_chip, read_nbr, read_all,
            ramp_dir, comp_dir, rcap, thr, cmod};
  endfunction

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; shift_en = 1;
    @(negedge clk); shift_en = 0; ser_in = ~b;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); mode_init = m; mode_chg = 1;
    @(negedge clk); mode_chg = 0;
  endtask

  task automatic do_strobe(input int hold, input logic exp_pulse, input string req);
    @(negedge clk); strobe = 1;
    @(negedge clk); chk(req, ptr_rst, exp_pulse);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk); chk("R10 single pulse", ptr_rst, 0);
    end
    strobe = 0;
    @(negedge clk); chk("R7 pulse width", ptr_rst, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:183] prev, cur;
    logic [50:0] old_f;
    repeat (3) @(negedge clk);
    chk("R1 fields", fields_now(), 0);
    chk("R1 mask", mask, 0);
    chk("R1 ctrl", {init_mode, ptr_rst, ser_out}, 0);
    rst_n = 1;

    // mode request without change strobe is ignored
    @(negedge clk); mode_init = 1;
    repeat (2) @(negedge clk);
    chk("R2 no chg", init_mode, 0);
    shift_bit(1'b1);
    chk("R3 shift gated", {mask, ser_out}, 0);
    do_strobe(1, 0, "R7 no pulse idle");
    set_mode(1);
    chk("R2 chg latch", init_mode, 1);

    prev = '0;
    old_f = '0;
    for (int v = 0; v < 3; v++) begin
      cur = build(VEC[v]);
      for (int k = 1; k <= 183; k++) begin
        shift_bit(cur[k]);
        chk("R4 ser_o order", ser_out, (k < 183) ? prev[k+1] : cur[1]);
      end
      for (int j = 0; j < 128; j++) chk("R5 mask bit", mask[j], cur[1+j]);
      chk("R5 mask word", mask, mask_of(VEC[v][31:0]));
      chk("R6 no strobe", fields_now(), old_f);
      do_strobe(1 + v, 1, "R7 pulse");
      chk("R8 fe fields", fields_now() >> 36, VEC[v][82:68]);
      chk("R9 be fields", fields_now() & 51'hF_FFFF_FFFF, VEC[v][67:32] & 36'hF_FFFF_FFFF);
      chk("R6 latched", fields_now(), VEC[v][82:32]);
      old_f = VEC[v][82:32];
      prev = cur;
    end

    // leave init: output forced low, shifts and strobes ignored
    set_mode(0);
    chk("R4 ser_o idle", ser_out, 0);
    for (int k = 0; k < 4; k++) shift_bit(1'b0);
    chk("R3 mask held", mask, mask_of(VEC[2][31:0]));
    do_strobe(1, 0, "R7 no pulse idle");
    chk("R6 fields held", fields_now(), old_f);
    set_mode(1);
    chk("R3 chain kept", ser_out, prev[1]);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 reset again", {fields_now(), init_mode, ptr_rst, ser_out}, 0);
    chk("R1 mask again", mask, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule